// File: doc/BRIEF.md
# Wake-Event Successive Approximation Sequencer

This block estimates a supply node voltage as a 5-bit fraction of the battery voltage. A trial code N stands for N/64 of the battery voltage, so the largest code, 31, stands for 31/64. The block drives the reference code of an external comparator DAC. It then arms an external timeout timer and asks the system to sleep. The decision for each bit comes from whichever wake event ends that sleep interval:

- A comparator trip means the trial code is too high.
- A timeout expiry means no trip happened, so the trial code is not too high.
- An undervoltage monitor trip cancels the measurement.

The block never samples the comparator level directly. The comparator, the timer and the conversion of the result into a voltage stay outside the block.

A host pulses start while the block is idle. Five arm/sleep/decide rounds follow, and then done pulses for one cycle with the 5-bit result. If the monitor trips first, the block stops and raises a flag. The flag tells the host to put the charge pump into bypass. There is no streaming data path: the result is a plain registered value, so there is no valid/ready handshake and no back-pressure. The host reads the result whenever done has pulsed, and the value stays put until the next accepted start.

Top module: `wake_sar_seq`

## Requirements
- R1: After reset, the DAC code and the result are 0. The timer-arm, sleep-request, done and abort outputs are all low.
- R2: A start pulse seen while idle begins a measurement. In the next cycle the DAC code is 16 (0x10), the timer-arm strobe is high and the timer load value equals the TIMEOUT_CYC parameter. The abort flag is cleared.
- R3: Each trial raises the timer-arm strobe for exactly one cycle. The sleep request follows for exactly one cycle in the next cycle, and only after that does the block accept wake events.
- R4: A comparator event ends the current trial by clearing the bit under test and setting the next lower bit. From 0x10 the next trial code is 0x08.
- R5: A timeout event ends the current trial by keeping the bit under test and setting the next lower bit. From 0x10 the next trial code is 0x18.
- R6: After the fifth decision, done is high for exactly one cycle, in the cycle after the deciding event. The result then equals min(floor(64·V/Vbat), 31), where a trial code N trips the comparator when N/64 exceeds V/Vbat. The result holds until the next accepted start.
- R7: A monitor event ends the measurement. In the next cycle the abort flag is high, and afterwards no further arm strobe and no done pulse occur. The result keeps its previous value and the abort flag stays high until the next accepted start.
- R8: When events coincide, monitor beats comparator and comparator beats timeout.
- R9: Wake events that arrive while the block is idle, or during the arm and sleep-request cycles, have no effect on any output.
- R10: A start pulse during a measurement is ignored: the trial code and the strobes carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a measurement (honoured when idle) |
| cmp_trip_i | input | 1 | Comparator trip pulse (code too high) |
| tmo_done_i | input | 1 | Timeout expiry pulse (no trip) |
| mon_trip_i | input | 1 | Undervoltage monitor trip pulse (abort) |
| dac_code_o | output | CODE_W | Trial reference code to the comparator DAC |
| tmr_arm_o | output | 1 | One-cycle strobe that loads and starts the timeout timer |
| tmr_load_o | output | TMR_W | Timeout length in clock cycles |
| sleep_req_o | output | 1 | One-cycle sleep request after arming |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| abort_o | output | 1 | Measurement aborted; host should bypass the pump |
| result_o | output | CODE_W | Final code of the last completed measurement |

## Verification
A wrong bit pointer or a wrong trial register shows up at once on dac_code_o, in the arm cycle right after the deciding event. It then shows up again in result_o when done pulses. The bench therefore sweeps every node voltage in half-code steps and compares each trial code against the one it computes itself. A corrupted sequencer state shows within one or two cycles as a missing or doubled arm or sleep strobe. It can also show as a done or abort pulse that should not be there, or as an event that the block should have ignored but that moved the code.

// File: rtl/wsar_pkg.sv
package wsar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAIT  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LOWER = 2'd1,
    EV_RAISE = 2'd2,
    EV_ABORT = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/wsar_evt_arb.sv
module wsar_evt_arb
  import wsar_pkg::*;
(
  input  logic     armed_i,
  input  logic     cmp_i,
  input  logic     tmo_i,
  input  logic     mon_i,
  output ev_kind_e kind_o
);
  // Priority: monitor, then comparator, then timeout. Nothing counts unless armed.
  always_comb begin
    kind_o = EV_NONE;
    if (armed_i) begin
      if (mon_i)      kind_o = EV_ABORT;
      else if (cmp_i) kind_o = EV_LOWER;
      else if (tmo_i) kind_o = EV_RAISE;
    end
  end
endmodule

// File: rtl/wsar_code_reg.sv
module wsar_code_reg #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first_i,
  input  logic              decide_i,
  input  logic              lower_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] next_code_o,
  output logic              last_o
);
  localparam logic [CODE_W-1:0] FIRST = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, mask_q;

  // Next trial: drop or keep the bit under test, then set the bit below it.
  always_comb begin
    next_code_o = lower_i ? (code_q & ~mask_q) : code_q;
    next_code_o = next_code_o | (mask_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load_first_i) begin
      code_q <= FIRST;
      mask_q <= FIRST;
    end else if (decide_i) begin
      code_q <= next_code_o;
      mask_q <= mask_q >> 1;
    end
  end

  assign code_o = code_q;
  assign last_o = mask_q[0];

  assert_first_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_first_i |=> code_o == FIRST);
  assert_cmp_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && lower_i && !last_o && !load_first_i) |=> code_o < $past(code_o));
  assert_tmo_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && !lower_i && !last_o && !load_first_i) |=> code_o > $past(code_o));
endmodule

// File: rtl/wsar_fsm.sv
module wsar_fsm
  import wsar_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  ev_kind_e          kind_i,
  input  logic              last_i,
  input  logic [CODE_W-1:0] next_code_i,
  output logic              armed_o,
  output logic              load_first_o,
  output logic              decide_o,
  output logic              lower_o,
  output logic              arm_o,
  output logic              sleep_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [CODE_W-1:0] result_o
);
  seq_st_e st_q, st_d;
  logic done_q, abort_q;
  logic [CODE_W-1:0] result_q;

  assign armed_o      = (st_q == ST_WAIT);
  assign load_first_o = (st_q == ST_IDLE) && start_i;
  assign decide_o     = (kind_i == EV_LOWER) || (kind_i == EV_RAISE);
  assign lower_o      = (kind_i == EV_LOWER);
  assign arm_o        = (st_q == ST_ARM);
  assign sleep_o      = (st_q == ST_SLEEP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_ARM;
      ST_ARM:   st_d = ST_SLEEP;
      ST_SLEEP: st_d = ST_WAIT;
      ST_WAIT: begin
        if (kind_i == EV_ABORT)   st_d = ST_IDLE;
        else if (decide_o)        st_d = last_i ? ST_IDLE : ST_ARM;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      result_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (load_first_o) abort_q <= 1'b0;
      if (kind_i == EV_ABORT) abort_q <= 1'b1;
      if (decide_o && last_i) begin
        done_q   <= 1'b1;
        result_q <= next_code_i;
      end
    end
  end

  assign done_o   = done_q;
  assign abort_o  = abort_q;
  assign result_o = result_q;

  assert_arm_then_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> (sleep_o && !arm_o));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_not_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !abort_o);
  assert_unarmed_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |=> !done_o);
  assert_unarmed_abort_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !load_first_o) |=> $stable(abort_o));
endmodule

// File: rtl/wake_sar_seq.sv
module wake_sar_seq
  import wsar_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int TIMEOUT_CYC = 50000,
  parameter int TMR_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_trip_i,
  input  logic              tmo_done_i,
  input  logic              mon_trip_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              tmr_arm_o,
  output logic [TMR_W-1:0]  tmr_load_o,
  output logic              sleep_req_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [CODE_W-1:0] result_o
);
  ev_kind_e          kind;
  logic              armed, load_first, decide, lower, last;
  logic [CODE_W-1:0] next_code;

  wsar_evt_arb u_arb (
    .armed_i (armed),
    .cmp_i   (cmp_trip_i),
    .tmo_i   (tmo_done_i),
    .mon_i   (mon_trip_i),
    .kind_o  (kind)
  );

  wsar_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_first_i (load_first),
    .decide_i     (decide),
    .lower_i      (lower),
    .code_o       (dac_code_o),
    .next_code_o  (next_code),
    .last_o       (last)
  );

  wsar_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .kind_i       (kind),
    .last_i       (last),
    .next_code_i  (next_code),
    .armed_o      (armed),
    .load_first_o (load_first),
    .decide_o     (decide),
    .lower_o      (lower),
    .arm_o        (tmr_arm_o),
    .sleep_o      (sleep_req_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .result_o     (result_o)
  );

  assign tmr_load_o = TMR_W'(TIMEOUT_CYC);

  assert_mon_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mon_trip_i) |=> (abort_o && !tmr_arm_o));
  assert_busy_code_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load_first) |=> $stable(dac_code_o));
endmodule

// File: tb/wake_sar_seq_tb.sv
module wake_sar_seq_tb_top;
  localparam int CW  = 5;
  localparam int TMO = 25;
  localparam int TW  = $clog2(TMO + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cmp = 1'b0, tmo = 1'b0, mon = 1'b0;
  logic [CW-1:0] code, result;
  logic [TW-1:0] tload;
  logic arm, slp, done, abrt;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  wake_sar_seq #(.CODE_W(CW), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_trip_i(cmp),
    .tmo_done_i(tmo), .mon_trip_i(mon), .dac_code_o(code), .tmr_arm_o(arm),
    .tmr_load_o(tload), .sleep_req_o(slp), .done_o(done), .abort_o(abrt),
    .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive an event pattern at a falling edge and drop it at the next one.
  task automatic pulse(input bit c, input bit t, input bit m, input bit s);
    cmp = c; tmo = t; mon = m; start = s;
    @(negedge clk);
    cmp = 0; tmo = 0; mon = 0; start = 0;
  endtask

  task automatic run_measure(input int v2);
    int e = 16;
    int exp_res = (v2 / 2 > 31) ? 31 : v2 / 2;
    pulse(0, 0, 0, 1);
    chk(abrt == 0, "R2 abort cleared", abrt, 0);
    for (int b = 4; b >= 0; b--) begin
      int h = (b > 0) ? (1 << (b - 1)) : 0;
      chk(arm == 1 && code == e, "R2/R4/R5 trial code", code, e);
      if (b == 4) chk(tload == TMO, "R2 timer load", tload, TMO);
      @(negedge clk);
      chk(slp == 1 && arm == 0, "R3 sleep follows arm", slp, 1);
      @(negedge clk);
      chk(slp == 0, "R3 sleep one cycle", slp, 0);
      if (2 * e > v2) begin pulse(1, 0, 0, 0); e = e - (1 << b) + h; end
      else begin pulse(0, 1, 0, 0); e = e + h; end
    end
    chk(done == 1, "R6 done pulse", done, 1);
    chk(result == exp_res, "R6 result", result, exp_res);
    @(negedge clk);
    chk(done == 0, "R6 done one cycle", done, 0);
    chk(result == exp_res, "R6 result held", result, exp_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] keep;
    repeat (3) @(negedge clk);
    chk(code == 0 && result == 0, "R1 reset codes", code, 0);
    chk({arm, slp, done, abrt} == 4'b0, "R1 reset strobes", {arm, slp, done, abrt}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: sweep of node voltage in half-code steps, past full scale
    for (int v2 = 0; v2 <= 66; v2++) run_measure(v2);

    // R9: events while idle change nothing
    keep = result;
    pulse(1, 1, 1, 0);
    chk(abrt == 0 && done == 0 && arm == 0, "R9 idle events ignored", abrt, 0);
    chk(result == keep && code == keep, "R9 idle code held", result, keep);

    // R8 comparator beats timeout; R9 event in arm cycle ignored
    pulse(0, 0, 0, 1);
    pulse(1, 0, 0, 0);           // during arm: ignored
    @(negedge clk);              // now in wait
    pulse(1, 1, 0, 0);
    chk(arm == 1 && code == 8, "R8 cmp over tmo", code, 8);
    pulse(0, 0, 1, 0);           // monitor during arm: ignored
    chk(abrt == 0, "R9 arm-cycle monitor ignored", abrt, 0);
    @(negedge clk);
    // R10: start in wait is ignored
    pulse(0, 0, 0, 1);
    chk(arm == 0 && code == 8 && abrt == 0, "R10 start ignored", code, 8);
    // R8 monitor beats comparator -> R7 abort
    keep = result;
    pulse(1, 0, 1, 0);
    chk(abrt == 1 && done == 0, "R7/R8 abort raised", abrt, 1);
    repeat (4) begin
      @(negedge clk);
      chk(arm == 0 && done == 0 && abrt == 1, "R7 stays aborted", arm, 0);
    end
    chk(result == keep, "R7 result kept", result, keep);

    // R5 then R7 in second trial, then R2 recovery clears abort
    pulse(0, 0, 0, 1);
    repeat (2) @(negedge clk);
    pulse(0, 1, 0, 0);
    chk(code == 24, "R5 raise to 0x18", code, 24);
    repeat (2) @(negedge clk);
    pulse(0, 0, 1, 0);
    chk(abrt == 1, "R7 abort in trial two", abrt, 1);
    run_measure(20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule